// File: doc/BRIEF.md
# Page Write Buffer with Self-Timed Commit

This block sits behind a serial-memory protocol engine and handles the write half of its storage path. The engine hands it a transaction start with a byte address and the level of a write-inhibit input. It then passes each received data byte and finally a stop strobe. The stop strobe carries a flag that says whether the stop fell in the bit slot directly after an acknowledged byte. Accepted bytes are gathered in a 32-lane row latch, one lane per byte of a memory row. The engine gets a same-cycle acknowledge for every byte the block accepts.

A stop in the correct slot launches a write cycle. The cycle lasts a fixed number of system clocks, set by a parameter. During it the block raises `busy` and ignores every request. At the last clock of the cycle, the lanes that received a byte are copied into a behavioural byte array, and the other lanes of that row are left alone. The block then drops `busy`, pulses `busy_done` and moves its address counter to the byte after the last one written. The array comes out of reset holding 0xFF everywhere. A combinational read port exposes its contents.

Top module: `pgw_top`

## Requirements
- R1: After reset every array location reads 0xFF on `rd_data`, `busy` and `busy_done` are low and `addr_cnt` is 0.
- R2: A byte is accepted and `byte_ack` is high in the same cycle only under all of these conditions: a transaction is open, its inhibit is low, `byte_vld` is high, and neither `txn_start` nor `stop_vld` is high in that cycle.
- R3: Each accepted byte goes to the lane given by the low five bits of an in-row pointer. The pointer starts at the low five bits of `txn_addr`. After each byte only those five bits increment, so lane 31 is followed by lane 0 of the same row.
- R4: A write cycle starts only if `stop_vld` arrives with `stop_after_ack` high and at least one byte was accepted. A stop with `stop_after_ack` low, or with no byte accepted, closes the transaction and discards the latch.
- R5: A commit writes only the lanes that received a byte. Every other location, including the rest of the row, keeps its value.
- R6: `busy` rises in the cycle after the accepted stop and stays high for exactly TW_CYCLES cycles. In the first cycle with `busy` low, `busy_done` is high for one cycle and the committed bytes are visible on `rd_data`.
- R7: While `busy` is high, `txn_start`, `byte_vld` and `stop_vld` have no effect, and `byte_ack` stays low.
- R8: `addr_cnt` takes `txn_addr` in the cycle after `txn_start`. When a write cycle ends, it becomes the last written address plus one, wrapping over the full address space. In all other cycles it holds.
- R9: If `wr_inhibit` is high with `txn_start`, that transaction acknowledges no byte, latches nothing and never starts a write cycle.
- R10: If more than 32 bytes arrive, the pointer rolls over and a later byte replaces the earlier byte in the same lane. Only the final value of each lane is committed.
- R11: A `txn_start` while a transaction is open discards the latch and opens a new transaction with the new address and inhibit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_start | input | 1 | Opens a write transaction |
| txn_addr | input | ADDR_W | Byte address of the transaction |
| wr_inhibit | input | 1 | Write protect level, sampled with `txn_start` |
| byte_vld | input | 1 | Data byte strobe |
| byte_data | input | 8 | Data byte |
| byte_ack | output | 1 | Byte accepted (combinational) |
| stop_vld | input | 1 | Stop condition strobe |
| stop_after_ack | input | 1 | Stop fell in the slot right after an acknowledged byte |
| busy | output | 1 | Write cycle in progress |
| busy_done | output | 1 | One-cycle pulse when the write cycle ends |
| addr_cnt | output | ADDR_W | Address counter |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array contents at `rd_addr` |

## Verification
The bench starts a page at lane 30 so the pointer has to wrap inside the row. A design that carried into the row bits would write the next row instead. It drives 34 bytes to check that the early lanes are overwritten and not extended. It writes a partial row over earlier data, where a design that committed the whole latch would clobber bytes it never received. It also sends stops in the wrong slot, an empty stop, an inhibited transaction, a restart, traffic during a write cycle and a write to the top address. In each of these cases a faulty design would either start a spurious write cycle or leave `addr_cnt` at a wrong value.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_COLLECT = 2'd1,
        PH_WRITE   = 2'd2
    } phase_e;

    typedef struct packed {
        logic valid;
        logic after_ack;
    } stop_t;

    // A stop launches a write cycle only in the slot after an ack,
    // with writes enabled and at least one byte held.
    function automatic logic commit_ok(stop_t s, logic inhibit, logic any_byte);
        return s.valid && s.after_ack && !inhibit && any_byte;
    endfunction

endpackage

// File: rtl/pgw_latch.sv
module pgw_latch
    import pgw_pkg::*;
#(
    parameter int LANE_W = 5,
    localparam int LANES = 1 << LANE_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic [LANE_W-1:0]       clear_lane,
    input  logic                    capture,
    input  byte_t                   din,
    output logic [LANES-1:0]        mask,
    output byte_t [LANES-1:0]       lane_data,
    output logic [LANE_W-1:0]       last_lane
);

    logic [LANE_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask      <= '0;
            ptr_q     <= '0;
            last_lane <= '0;
            lane_data <= '0;
        end else if (clear) begin
            mask  <= '0;
            ptr_q <= clear_lane;
        end else if (capture) begin
            lane_data[ptr_q] <= din;
            mask[ptr_q]      <= 1'b1;
            last_lane        <= ptr_q;
            ptr_q            <= ptr_q + 1'b1;
        end
    end

endmodule

// File: rtl/pgw_timer.sv
module pgw_timer #(
    parameter int TW_CYCLES = 200,
    localparam int CNT_W = $clog2(TW_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic launch,
    output logic busy,
    output logic expire,
    output logic done
);

    logic [CNT_W-1:0] cnt_q;

    assign expire = busy && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= expire;
            if (launch) begin
                busy  <= 1'b1;
                cnt_q <= CNT_W'(TW_CYCLES - 1);
            end else if (expire) begin
                busy <= 1'b0;
            end else if (busy) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/pgw_array.sv
module pgw_array
    import pgw_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int LANE_W = 5,
    localparam int LANES = 1 << LANE_W,
    localparam int ROW_W = ADDR_W - LANE_W,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                commit,
    input  logic [ROW_W-1:0]    row,
    input  logic [LANES-1:0]    mask,
    input  byte_t [LANES-1:0]   lane_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output byte_t               rd_data
);

    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (commit) begin
            for (int l = 0; l < LANES; l++) begin
                if (mask[l]) mem[{row, LANE_W'(l)}] <= lane_data[l];
            end
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/pgw_top.sv
module pgw_top
    import pgw_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int LANE_W    = 5,
    parameter int TW_CYCLES = 200,
    localparam int LANES = 1 << LANE_W,
    localparam int ROW_W = ADDR_W - LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              txn_start,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic              wr_inhibit,
    input  logic              byte_vld,
    input  logic [7:0]        byte_data,
    output logic              byte_ack,
    input  logic              stop_vld,
    input  logic              stop_after_ack,
    output logic              busy,
    output logic              busy_done,
    output logic [ADDR_W-1:0] addr_cnt,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    phase_e            phase_q;
    logic [ROW_W-1:0]  row_q;
    logic              inhib_q;
    logic [LANES-1:0]  mask;
    byte_t [LANES-1:0] lane_data;
    logic [LANE_W-1:0] last_lane;
    logic              expire;
    stop_t             stop_s;

    logic collecting, clear, capture, launch;

    assign stop_s     = '{valid: stop_vld, after_ack: stop_after_ack};
    assign collecting = (phase_q == PH_COLLECT);
    assign clear      = (phase_q != PH_WRITE) && txn_start;
    assign capture    = collecting && byte_vld && !inhib_q && !txn_start && !stop_vld;
    assign launch     = collecting && !txn_start && commit_ok(stop_s, inhib_q, |mask);
    assign byte_ack   = capture;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            row_q    <= '0;
            inhib_q  <= 1'b0;
            addr_cnt <= '0;
        end else begin
            if (clear) begin
                row_q    <= txn_addr[ADDR_W-1:LANE_W];
                inhib_q  <= wr_inhibit;
                addr_cnt <= txn_addr;
            end else if (expire) begin
                addr_cnt <= {row_q, last_lane} + 1'b1;
            end
            unique case (phase_q)
                PH_IDLE: if (txn_start) phase_q <= PH_COLLECT;
                PH_COLLECT: begin
                    if (txn_start)     phase_q <= PH_COLLECT;
                    else if (launch)   phase_q <= PH_WRITE;
                    else if (stop_vld) phase_q <= PH_IDLE;
                end
                PH_WRITE: if (expire) phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    pgw_latch #(.LANE_W(LANE_W)) u_latch (
        .clk        (clk),
        .rst        (rst),
        .clear      (clear),
        .clear_lane (txn_addr[LANE_W-1:0]),
        .capture    (capture),
        .din        (byte_data),
        .mask       (mask),
        .lane_data  (lane_data),
        .last_lane  (last_lane)
    );

    pgw_timer #(.TW_CYCLES(TW_CYCLES)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .launch (launch),
        .busy   (busy),
        .expire (expire),
        .done   (busy_done)
    );

    pgw_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_array (
        .clk       (clk),
        .rst       (rst),
        .commit    (expire),
        .row       (row_q),
        .mask      (mask),
        .lane_data (lane_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
    parameter int ADDR_W    = 9,
    parameter int TW_CYCLES = 200
) (
    input logic              clk,
    input logic              rst,
    input logic              txn_start,
    input logic              byte_ack,
    input logic              stop_vld,
    input logic              stop_after_ack,
    input logic              busy,
    input logic              busy_done,
    input logic [ADDR_W-1:0] addr_cnt
);

    int unsigned run_q;

    always_ff @(posedge clk) begin
        if (rst)       run_q <= 0;
        else if (busy) run_q <= run_q + 1;
        else           run_q <= 0;
    end

    assert_no_ack_busy_R7: assert property (@(posedge clk) disable iff (rst)
        busy |-> !byte_ack);

    assert_launch_slot_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(stop_vld && stop_after_ack));

    assert_busy_len_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_q == TW_CYCLES));

    assert_done_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> busy_done);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        busy_done |=> !busy_done);

    assert_cnt_moves_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(addr_cnt) |-> (busy_done || $past(txn_start)));

endmodule

bind pgw_top pgw_checker #(.ADDR_W(ADDR_W), .TW_CYCLES(TW_CYCLES)) u_pgw_chk (
    .clk            (clk),
    .rst            (rst),
    .txn_start      (txn_start),
    .byte_ack       (byte_ack),
    .stop_vld       (stop_vld),
    .stop_after_ack (stop_after_ack),
    .busy           (busy),
    .busy_done      (busy_done),
    .addr_cnt       (addr_cnt)
);

// File: tb/tb_pgw_top.sv
`timescale 1ns/1ps
module tb_pgw_top;

    localparam int AW = 9;
    localparam int TW = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          txn_start, wr_inhibit, byte_vld, stop_vld, stop_after_ack;
    logic [AW-1:0] txn_addr, rd_addr;
    logic [7:0]    byte_data, rd_data;
    logic          byte_ack, busy, busy_done;
    logic [AW-1:0] addr_cnt;

    always #4 clk = ~clk;

    pgw_top #(.ADDR_W(AW), .LANE_W(5), .TW_CYCLES(TW)) dut (
        .clk(clk), .rst(rst), .txn_start(txn_start), .txn_addr(txn_addr),
        .wr_inhibit(wr_inhibit), .byte_vld(byte_vld), .byte_data(byte_data),
        .byte_ack(byte_ack), .stop_vld(stop_vld), .stop_after_ack(stop_after_ack),
        .busy(busy), .busy_done(busy_done), .addr_cnt(addr_cnt),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    // behavioural reference model
    int ref_mem [DEPTH];
    int m_state;            // 0 idle, 1 collecting, 2 writing
    bit m_inh, m_busy, m_done;
    int m_ptr, m_row, m_last, m_cnt, m_tw;
    bit m_mask [32];
    int m_data [32];

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit any_mask();
        for (int l = 0; l < 32; l++) if (m_mask[l]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
        m_state = 0; m_inh = 0; m_busy = 0; m_done = 0;
        m_ptr = 0; m_row = 0; m_last = 0; m_cnt = 0; m_tw = 0;
        for (int l = 0; l < 32; l++) begin m_mask[l] = 0; m_data[l] = 0; end
    endfunction

    function automatic void model_step(bit ts, int a, bit wi, bit bv, int bd, bit sv, bit sa);
        m_done = 0;
        if (m_busy) begin
            if (m_tw == 1) begin
                for (int l = 0; l < 32; l++)
                    if (m_mask[l]) ref_mem[m_row * 32 + l] = m_data[l];
                m_cnt  = (m_row * 32 + m_last + 1) % DEPTH;
                m_busy = 0; m_done = 1; m_state = 0;
            end else m_tw--;
        end else if (ts) begin
            m_state = 1; m_inh = wi; m_cnt = a;
            m_row = a / 32; m_ptr = a % 32;
            for (int l = 0; l < 32; l++) m_mask[l] = 0;
        end else if (m_state == 1) begin
            if (sv) begin
                if (sa && !m_inh && any_mask()) begin
                    m_state = 2; m_busy = 1; m_tw = TW;
                end else m_state = 0;
            end else if (bv && !m_inh) begin
                m_data[m_ptr] = bd; m_mask[m_ptr] = 1;
                m_last = m_ptr; m_ptr = (m_ptr + 1) % 32;
            end
        end
    endfunction

    task automatic cyc(bit ts, int a, bit wi, bit bv, int bd, bit sv, bit sa);
        bit exp_ack;
        txn_start = ts; txn_addr = a[AW-1:0]; wr_inhibit = wi;
        byte_vld = bv; byte_data = bd[7:0]; stop_vld = sv; stop_after_ack = sa;
        #2;
        exp_ack = (m_state == 1) && bv && !m_inh && !ts && !sv;
        chk(m_busy ? "R7" : (m_inh ? "R9" : "R2"), "byte_ack", int'(byte_ack), int'(exp_ack));
        @(posedge clk);
        model_step(ts, a, wi, bv, bd, sv, sa);
        @(negedge clk);
        chk("R6", "busy", int'(busy), int'(m_busy));
        chk("R6", "busy_done", int'(busy_done), int'(m_done));
        chk("R8", "addr_cnt", int'(addr_cnt), m_cnt);
        chk("R5", "rd_data", int'(rd_data), ref_mem[int'(rd_addr)]);
    endtask

    task automatic idle();                 cyc(0, 0, 0, 0, 0, 0, 0); endtask
    task automatic start(int a, bit wi);   cyc(1, a, wi, 0, 0, 0, 0); endtask
    task automatic send(int d);            cyc(0, 0, 0, 1, d, 0, 0); endtask
    task automatic stop(bit sa);           cyc(0, 0, 0, 0, 0, 1, sa); endtask
    task automatic drain();
        for (int i = 0; i < TW + 3; i++) idle();
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        txn_start = 0; txn_addr = 0; wr_inhibit = 0; byte_vld = 0; byte_data = 0;
        stop_vld = 0; stop_after_ack = 0; rd_addr = 0;
        rst = 1;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "busy_done", int'(busy_done), 0);
        chk("R1", "addr_cnt", int'(addr_cnt), 0);
        chk("R1", "rd_data[0]", int'(rd_data), 8'hFF);
        rd_addr = AW'(DEPTH - 1); #1;
        chk("R1", "rd_data[top]", int'(rd_data), 8'hFF);

        // R4 R6 R8: single byte write
        rd_addr = 9'h045;
        start(9'h045, 0); send(8'hA5); stop(1); drain();

        // R3: page starting at lane 30 wraps inside row
        rd_addr = 9'h040;
        start(9'h05E, 0); send(8'h11); send(8'h22); send(8'h33); send(8'h44); stop(1);
        // R7: traffic during busy is ignored
        start(9'h100, 0); send(8'h99); stop(1); send(8'h98);
        drain();

        // R4: stop in the wrong slot discards
        rd_addr = 9'h120;
        start(9'h120, 0); send(8'h5A); send(8'h5B); stop(0); drain();

        // R4: empty stop launches nothing
        start(9'h130, 0); stop(1); drain();

        // R9: inhibited transaction
        rd_addr = 9'h045;
        start(9'h045, 1); send(8'h00); send(8'h01); stop(1); drain();

        // R11: restart discards first latch
        rd_addr = 9'h150;
        start(9'h150, 0); send(8'hC1); start(9'h151, 0); send(8'hC2); stop(1); drain();

        // R5: partial row keeps older lanes
        rd_addr = 9'h05E;
        start(9'h05F, 0); send(8'h77); stop(1); drain();

        // R10: 34 bytes roll over lanes 0 and 1
        rd_addr = 9'h0A0;
        start(9'h0A0, 0);
        for (int i = 0; i < 34; i++) send(8'h80 + i);
        stop(1); drain();

        // R8: top address wraps the counter to zero
        rd_addr = 9'h1FF;
        start(9'h1FF, 0); send(8'h3C); stop(1); drain();

        // full array sweep against the model (R5)
        for (int a = 0; a < DEPTH; a++) begin
            rd_addr = AW'(a);
            idle();
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule